// File: doc/BRIEF.md
# Transmit Collision Count Register

This block keeps the number of collisions that a single outgoing frame runs into across its transmit attempts. The transmit MAC reports three one-cycle strobes: a collision, a successful completion and an abort because of too many collisions. The CPU's transmit-start command opens a new transmission and wipes the previous result. Alongside the count, the block raises two status flags: one that marks that a collision was seen and one that marks an abort. These flags feed a transmit status register kept elsewhere.

The CPU reads one byte. The count sits in the low nibble and the upper nibble is always zero. The count reads zero in two cases: when the frame went out with no collision, and when it was abandoned on excessive collisions. The MAC declares that abort on the sixteenth collision of a frame, so the four-bit count never has to pass fifteen. Strobes that arrive while no transmission is open are ignored.

Top module: `txcol_count_reg`

## Requirements
- R1: Bits 3..0 of `ncol_byte_o` carry the count and bits 7..4 always read as zero.
- R2: While reset is asserted, and just after it, the count is 0, both flags are 0 and no transmission is open.
- R3: A cycle with `tx_go_i` high opens a transmission, and from the next cycle on the count, `col_seen_o` and `abort_seen_o` read 0.
- R4: Each cycle with `col_hit_i` high during an open transmission raises the count by one from the next cycle on.
- R5: The strobes `col_hit_i`, `tx_ok_i` and `tx_abort_i` change nothing while no transmission is open, whether before the first start or after a completion or an abort.
- R6: `col_seen_o` goes high on the first accepted collision and stays high until the next `tx_go_i`. Whenever the count is non-zero, `col_seen_o` is high.
- R7: A transmission that completes through `tx_ok_i` with no collision leaves the count at 0 and `col_seen_o` low.
- R8: `tx_abort_i` during an open transmission sets `abort_seen_o`, makes the count read 0 and closes the transmission.
- R9: When `tx_go_i` and `col_hit_i` are high in the same cycle, the clear wins: the count and `col_seen_o` read 0 in the next cycle.
- R10: A collision that arrives when the count is already 15, with no abort, leaves the count at 15. The count never wraps.
- R11: `tx_ok_i` closes the transmission, and the count and `col_seen_o` then hold their values until the next `tx_go_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_go_i | input | 1 | CPU transmit-start command, one-cycle pulse |
| col_hit_i | input | 1 | Collision strobe from the transmit MAC |
| tx_ok_i | input | 1 | Transmit-complete strobe |
| tx_abort_i | input | 1 | Excessive-collision abort strobe |
| ncol_byte_o | output | 8 | Readable byte: count in bits 3..0, zeros above |
| col_seen_o | output | 1 | Collision status flag |
| abort_seen_o | output | 1 | Abort status flag |

## Verification
The hardest state to reach is a count of fifteen followed by one more collision without an abort. The MAC would never produce that sequence, yet it is the only way to show that the count does not wrap. The bench reaches it with a directed run of fifteen collision strobes in one transmission, then a sixteenth one alone, then an abort. Strobes outside an open transmission, and a start and a collision in the same cycle, are also hard to arrange from the ports. The vector table places each of them right after a completion, an abort or a reset.

// File: rtl/txcol_pkg.sv
package txcol_pkg;
  localparam int CNT_W  = 4;
  localparam int BYTE_W = 8;

  typedef logic [CNT_W-1:0] cnt_t;

  // Saturating increment: at the all-ones value the count stays put.
  function automatic cnt_t sat_inc(input cnt_t v);
    if (v == {CNT_W{1'b1}}) return v;
    return v + cnt_t'(1);
  endfunction

  // Place the count in the low bits of the read byte, zeros above.
  function automatic logic [BYTE_W-1:0] pack_byte(input cnt_t v);
    return {{(BYTE_W-CNT_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/txcol_track.sv
module txcol_track (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic end_i,
  output logic active_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     active_o <= 1'b0;
    else if (go_i)  active_o <= 1'b1;
    else if (end_i) active_o <= 1'b0;
  end
endmodule

// File: rtl/txcol_counter.sv
module txcol_counter
  import txcol_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic zero_i,
  input  logic inc_i,
  output cnt_t cnt_o
);
  cnt_t cnt_nx;

  always_comb begin
    cnt_nx = cnt_o;
    if (clr_i || zero_i) cnt_nx = '0;
    else if (inc_i)      cnt_nx = sat_inc(cnt_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_nx;
  end
endmodule

// File: rtl/txcol_flags.sv
module txcol_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic col_i,
  input  logic abt_i,
  output logic col_flag_o,
  output logic abt_flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_flag_o <= 1'b0;
      abt_flag_o <= 1'b0;
    end else if (clr_i) begin
      col_flag_o <= 1'b0;
      abt_flag_o <= 1'b0;
    end else begin
      if (col_i) col_flag_o <= 1'b1;
      if (abt_i) abt_flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/txcol_count_reg.sv
module txcol_count_reg
  import txcol_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_go_i,
  input  logic              col_hit_i,
  input  logic              tx_ok_i,
  input  logic              tx_abort_i,
  output logic [BYTE_W-1:0] ncol_byte_o,
  output logic              col_seen_o,
  output logic              abort_seen_o
);
  // Named internal events, used by the bound checker.
  logic active;
  logic clr_ev;
  logic col_ev;
  logic abt_ev;
  logic end_ev;
  cnt_t cnt;

  // The start command wins over every MAC strobe in the same cycle.
  assign clr_ev = tx_go_i;
  assign col_ev = active & col_hit_i  & ~tx_go_i;
  assign abt_ev = active & tx_abort_i & ~tx_go_i;
  assign end_ev = active & (tx_ok_i | tx_abort_i) & ~tx_go_i;

  txcol_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (clr_ev),
    .end_i    (end_ev),
    .active_o (active)
  );

  txcol_counter u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_ev),
    .zero_i (abt_ev),
    .inc_i  (col_ev),
    .cnt_o  (cnt)
  );

  txcol_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_ev),
    .col_i      (col_ev),
    .abt_i      (abt_ev),
    .col_flag_o (col_seen_o),
    .abt_flag_o (abort_seen_o)
  );

  assign ncol_byte_o = pack_byte(cnt);
endmodule

// File: rtl/txcol_count_reg_chk.sv
module txcol_count_reg_chk
  import txcol_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tx_go_i,
  input logic              col_hit_i,
  input logic              tx_ok_i,
  input logic              tx_abort_i,
  input logic              active,
  input logic [BYTE_W-1:0] ncol_byte_o,
  input logic              col_seen_o,
  input logic              abort_seen_o
);
  logic [CNT_W-1:0] c;
  assign c = ncol_byte_o[CNT_W-1:0];

  p_hi_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ncol_byte_o[BYTE_W-1:CNT_W] == '0);

  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go_i |=> (c == '0) && !col_seen_o && !abort_seen_o && active);

  p_increment_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && col_hit_i && !tx_go_i && !tx_abort_i && c != {CNT_W{1'b1}})
      |=> c == $past(c) + 1'b1);

  p_idle_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !tx_go_i)
      |=> $stable(ncol_byte_o) && $stable(col_seen_o) && $stable(abort_seen_o) && !active);

  p_flag_follows_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c != '0) |-> col_seen_o);

  p_abort_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tx_abort_i && !tx_go_i) |=> abort_seen_o && c == '0 && !active);

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (c == {CNT_W{1'b1}} && !tx_go_i && !tx_abort_i) |=> c == {CNT_W{1'b1}});

  p_done_closes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tx_ok_i && !tx_go_i && !tx_abort_i)
      |=> !active && $stable(ncol_byte_o) && $stable(col_seen_o));
endmodule

bind txcol_count_reg txcol_count_reg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_go_i      (tx_go_i),
  .col_hit_i    (col_hit_i),
  .tx_ok_i      (tx_ok_i),
  .tx_abort_i   (tx_abort_i),
  .active       (active),
  .ncol_byte_o  (ncol_byte_o),
  .col_seen_o   (col_seen_o),
  .abort_seen_o (abort_seen_o)
);

// File: tb/txcol_count_reg_test.sv
`timescale 1ns/1ps
module txcol_count_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0, col = 1'b0, ok = 1'b0, abt = 1'b0;
  logic [7:0] byte_o;
  logic       colf, abtf;
  int         checks = 0;
  int         errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  txcol_count_reg uut (
    .clk(clk), .rst_n(rst_n), .tx_go_i(go), .col_hit_i(col),
    .tx_ok_i(ok), .tx_abort_i(abt),
    .ncol_byte_o(byte_o), .col_seen_o(colf), .abort_seen_o(abtf)
  );

  // Vector: {go, col, ok, abt, expected count[3:0], expected col flag, expected abort flag}
  localparam int NV = 19;
  localparam logic [9:0] VEC [NV] = '{
    10'b0100_0000_00,  // R5 collision before any start
    10'b0011_0000_00,  // R5 done and abort while idle
    10'b1000_0000_00,  // R3 start
    10'b0000_0000_00,
    10'b0010_0000_00,  // R7 done, no collision
    10'b0100_0000_00,  // R5 collision after done
    10'b1000_0000_00,  // R3 start
    10'b0100_0001_10,  // R4 R6 first collision
    10'b0000_0001_10,
    10'b0100_0010_10,  // R4
    10'b0100_0011_10,  // R4
    10'b0010_0011_10,  // R11 done holds count
    10'b0100_0011_10,  // R5 R11 collision after done
    10'b1100_0000_00,  // R9 start with collision, clear wins
    10'b0100_0001_10,  // R4
    10'b0101_0000_11,  // R8 abort zeroes count
    10'b0100_0000_11,  // R5 collision after abort
    10'b1000_0000_00,  // R3 start clears abort flag
    10'b0010_0000_00   // R7
  };

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: byte/col/abt actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive one cycle of strobes, then sample just after the clock edge.
  task automatic step(input logic [3:0] in);
    @(negedge clk);
    {go, col, ok, abt} = in;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [9:0] pack(input logic [7:0] b, input logic f, input logic a);
    return {b, f, a};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R2 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R2 reset", pack(byte_o, colf, abtf), 10'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9:6]);
      check($sformatf("R1 vector %0d", i), pack(byte_o, colf, abtf),
            {4'b0000, VEC[i][5:2], VEC[i][1:0]});
    end

    // R10: fifteen collisions, a sixteenth without abort, then the abort
    step(4'b1000);
    for (int k = 1; k <= 15; k++) step(4'b0100);
    check("R4 fifteen collisions", pack(byte_o, colf, abtf), {8'd15, 1'b1, 1'b0});
    step(4'b0100);
    check("R10 no wrap at 15", pack(byte_o, colf, abtf), {8'd15, 1'b1, 1'b0});
    step(4'b0101);
    check("R8 abort on sixteenth", pack(byte_o, colf, abtf), {8'd0, 1'b1, 1'b1});

    // R2: reset in the middle of a transmission, then an idle collision
    step(4'b1000);
    step(4'b0100);
    check("R6 flag before reset", pack(byte_o, colf, abtf), {8'd1, 1'b1, 1'b0});
    @(negedge clk);
    {go, col, ok, abt} = 4'b0000;
    rst_n = 1'b0;
    #2;
    check("R2 asynchronous reset", pack(byte_o, colf, abtf), 10'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(4'b0100);
    check("R2 idle after reset", pack(byte_o, colf, abtf), 10'b0);
    step(4'b0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule